// File: doc/BRIEF.md
# SPI Master with Programmable Serial Clock Divider

This block is a single-channel SPI master that produces its serial clock from the system clock through an 8-bit programmable divider. A one-cycle start pulse begins a transfer of one word of parameterised width. The block pulls its active-low select line, drives the transmit word most significant bit first, and collects a received word from the serial input. When the frame closes it raises a one-cycle done pulse.

The serial clock only runs during a transfer and rests high between transfers. The block drops select and puts the first data bit on the line at the same moment. The first clock transition, which is a falling edge, follows one full serial period later. Outgoing bits change on rising edges and incoming bits are sampled on falling edges. After the last rising edge the data output enable is removed. Select is released one high-phase later.

The divider value is captured when a transfer is accepted. It can therefore be changed at any time without disturbing a frame that is already running.

Top module: `spi_clkdiv_master`

## Requirements
- R1: The serial clock period is 1 + D system cycles, where D is the divider value captured at start. A divider value of 0 is handled as 1, which gives a period of 2.
- R2: For a period P, the low phase lasts floor(P/2) cycles and the high phase lasts ceil(P/2) cycles. An odd period therefore puts the extra cycle in the high phase.
- R3: On the clock edge that accepts a start, spi_ss_n goes to 0, spi_mosi_oe goes to 1 and spi_mosi carries tx_word[WORD_W-1]. The first falling edge of spi_sclk comes exactly one period after spi_ss_n falls.
- R4: spi_mosi changes only on rising edges of spi_sclk while a frame is open. It presents tx_word from the MSB down to the LSB, one bit per clock period.
- R5: spi_miso is sampled on each of the WORD_W falling edges of spi_sclk, MSB first. The resulting word appears on rx_word.
- R6: spi_mosi_oe drops on the WORD_W-th rising edge of spi_sclk. spi_ss_n returns to 1 one high-phase (ceil(P/2) cycles) after that edge.
- R7: done is a one-cycle pulse raised in the same cycle that spi_ss_n returns to 1. rx_word is valid from that cycle and stays unchanged until the next done.
- R8: spi_sclk rests at 1 whenever spi_ss_n is 1. Each transfer has exactly WORD_W falling and WORD_W rising edges.
- R9: A start pulse that arrives while a frame is open has no effect. The frame still carries the original word, and no second frame or done pulse follows.
- R10: While rst_n is 0 and after reset: spi_ss_n = 1, spi_sclk = 1, spi_mosi_oe = 0, done = 0 and rx_word = 0.
- R11: Changes to clk_div during an open frame do not alter its clock timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_div | input | DIV_W | Divider value D, captured at start |
| start | input | 1 | One-cycle request to begin a transfer |
| tx_word | input | WORD_W | Word to send, captured at start |
| spi_miso | input | 1 | Serial data from the slave |
| spi_sclk | output | 1 | Serial clock, rests high |
| spi_ss_n | output | 1 | Active-low slave select |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_mosi_oe | output | 1 | Drive enable for spi_mosi (0 means high impedance) |
| rx_word | output | WORD_W | Last received word |
| done | output | 1 | One-cycle pulse when rx_word is valid |

## Verification
Select, the first data bit and its enable are due on the edge that accepts the start, which is 1 cycle after the pulse is driven. The first falling clock edge comes P cycles later. After that, edges alternate every floor(P/2) and ceil(P/2) cycles, and select, done and the valid received word arrive ceil(P/2) cycles after the last rising edge. The bench keeps a cycle counter and time-stamps every output transition it sees at the falling system edge. It then compares the differences between time stamps with these expected distances, computed from the divider value, so that absolute latencies and sampling order do not change the result. A loopback slave model shifts its own word out on rising edges and captures spi_mosi on falling edges, which checks the bit order in both directions.

// File: rtl/spim_pkg.sv
// Shared types for the SPI master.
// Assumes: nothing beyond IEEE 1800-2017.
package spim_pkg;

    // Frame sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,   // select released, clock resting high
        ST_LEAD,   // select asserted, waiting one period
        ST_LOW,    // serial clock low phase
        ST_HIGH,   // serial clock high phase
        ST_TAIL    // after last rising edge, waiting one high phase
    } spim_state_e;

endpackage

// File: rtl/spim_phase_calc.sv
// Phase length calculator.
// Computes the serial period from the live divider input, for use at the
// start edge. It captures an effective divider at start and derives the low
// and high phase lengths from that captured value for the rest of the frame.
// Assumes: a divider of zero is treated as one.
module spim_phase_calc #(
    parameter int DIV_W = 8,
    localparam int PW = DIV_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [DIV_W-1:0] div_in,
    output logic [PW-1:0]    period_now,
    output logic [PW-1:0]    low_len,
    output logic [PW-1:0]    high_len
);

    logic [DIV_W-1:0] div_eff;
    logic [DIV_W-1:0] div_q;
    logic [PW-1:0]    period_q;

    // Clamp a zero divider up to one
    always_comb begin
        div_eff = (div_in == '0) ? DIV_W'(1) : div_in;
    end

    // Hold the divider for the duration of a frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= DIV_W'(1);
        end else if (capture) begin
            div_q <= div_eff;
        end
    end

    // Period now (for the lead-in) and phase split of the held period
    always_comb begin
        period_now = {1'b0, div_eff} + PW'(1);
        period_q   = {1'b0, div_q} + PW'(1);
        low_len    = period_q >> 1;
        high_len   = (period_q + PW'(1)) >> 1;
    end

endmodule

// File: rtl/spim_timer.sv
// Down-counting phase timer.
// On load it counts (load_val - 1) down to zero. expire is high in the last
// cycle of the loaded interval.
// Assumes: load_val is never zero.
module spim_timer #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expire
);

    logic [CW-1:0] cnt_q;

    // Load or count down, holding at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - CW'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    // Interval ends when the count reaches zero
    always_comb begin
        expire = (cnt_q == '0);
    end

endmodule

// File: rtl/spim_shifter.sv
// Transmit and receive shift registers, MSB first.
// The transmit MSB drives the serial output directly. Receive bits enter at
// the LSB end.
// Assumes: load, advance and sample are never asserted in the same cycle.
module spim_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              advance,
    input  logic              sample,
    input  logic              miso,
    output logic              mosi,
    output logic [WORD_W-1:0] rx_shift
);

    logic [WORD_W-1:0] tx_q;
    logic [WORD_W-1:0] rx_q;

    // Transmit register: load at start, move one place on each rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= tx_word;
        end else if (advance) begin
            tx_q <= {tx_q[WORD_W-2:0], 1'b0};
        end
    end

    // Receive register: take one bit on each falling edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (sample) begin
            rx_q <= {rx_q[WORD_W-2:0], miso};
        end
    end

    assign mosi     = tx_q[WORD_W-1];
    assign rx_shift = rx_q;

endmodule

// File: rtl/spim_ctrl.sv
// Frame sequencer.
// Steps through lead-in, alternating clock phases and tail, and drives the
// registered serial clock, select, output enable and done.
// Assumes: the timer reports expiry in the last cycle of each loaded interval.
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int CW     = 9,
    localparam int BCW   = (WORD_W > 2) ? $clog2(WORD_W) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          expire,
    input  logic [CW-1:0] period_now,
    input  logic [CW-1:0] low_len,
    input  logic [CW-1:0] high_len,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          cap_div,
    output logic          sh_load,
    output logic          sh_advance,
    output logic          sh_sample,
    output logic          finish,
    output logic          sclk,
    output logic          ss_n,
    output logic          oe,
    output logic          done
);

    spim_state_e    state_q, state_d;
    logic [BCW-1:0] bit_q;
    logic           last_bit;
    logic           to_low;
    logic           to_high;
    logic           last_rise;

    assign last_bit = (bit_q == BCW'(WORD_W - 1));

    // Next state and per-cycle strobes
    always_comb begin
        state_d    = state_q;
        tmr_load   = 1'b0;
        tmr_val    = low_len;
        cap_div    = 1'b0;
        sh_load    = 1'b0;
        sh_advance = 1'b0;
        sh_sample  = 1'b0;
        finish     = 1'b0;
        to_low     = 1'b0;
        to_high    = 1'b0;
        last_rise  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    tmr_load = 1'b1;
                    tmr_val  = period_now;
                    cap_div  = 1'b1;
                    sh_load  = 1'b1;
                    state_d  = ST_LEAD;
                end
            end
            ST_LEAD, ST_HIGH: begin
                if (expire) begin
                    tmr_load  = 1'b1;
                    tmr_val   = low_len;
                    sh_sample = 1'b1;
                    to_low    = 1'b1;
                    state_d   = ST_LOW;
                end
            end
            ST_LOW: begin
                if (expire) begin
                    tmr_load = 1'b1;
                    tmr_val  = high_len;
                    to_high  = 1'b1;
                    if (last_bit) begin
                        last_rise = 1'b1;
                        state_d   = ST_TAIL;
                    end else begin
                        sh_advance = 1'b1;
                        state_d    = ST_HIGH;
                    end
                end
            end
            ST_TAIL: begin
                if (expire) begin
                    finish  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Bit counter: cleared at start, advanced on each rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= '0;
        end else if (sh_load) begin
            bit_q <= '0;
        end else if (to_high && !last_bit) begin
            bit_q <= bit_q + BCW'(1);
        end
    end

    // Registered pin-side outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk <= 1'b1;
            ss_n <= 1'b1;
            oe   <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= finish;
            if (to_low) begin
                sclk <= 1'b0;
            end else if (to_high) begin
                sclk <= 1'b1;
            end
            if (sh_load) begin
                ss_n <= 1'b0;
                oe   <= 1'b1;
            end else begin
                if (last_rise) begin
                    oe <= 1'b0;
                end
                if (finish) begin
                    ss_n <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/spi_clkdiv_master.sv
// SPI master with a divided serial clock.
// Runs one MSB-first word per start pulse. The serial clock rests high and
// runs only inside a frame. Ignores start while a frame is open.
// Assumes: spi_miso is timed to the serial clock (no extra synchroniser).
module spi_clkdiv_master #(
    parameter int WORD_W = 8,
    parameter int DIV_W  = 8,
    localparam int CW    = DIV_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              start,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              spi_miso,
    output logic              spi_sclk,
    output logic              spi_ss_n,
    output logic              spi_mosi,
    output logic              spi_mosi_oe,
    output logic [WORD_W-1:0] rx_word,
    output logic              done
);

    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          expire;
    logic          cap_div;
    logic          sh_load;
    logic          sh_advance;
    logic          sh_sample;
    logic          finish;
    logic [CW-1:0] period_now;
    logic [CW-1:0] low_len;
    logic [CW-1:0] high_len;
    logic [WORD_W-1:0] rx_shift;
    logic [WORD_W-1:0] rx_q;

    spim_phase_calc #(.DIV_W(DIV_W)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (cap_div),
        .div_in     (clk_div),
        .period_now (period_now),
        .low_len    (low_len),
        .high_len   (high_len)
    );

    spim_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (expire)
    );

    spim_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .tx_word  (tx_word),
        .advance  (sh_advance),
        .sample   (sh_sample),
        .miso     (spi_miso),
        .mosi     (spi_mosi),
        .rx_shift (rx_shift)
    );

    spim_ctrl #(.WORD_W(WORD_W), .CW(CW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .expire     (expire),
        .period_now (period_now),
        .low_len    (low_len),
        .high_len   (high_len),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .cap_div    (cap_div),
        .sh_load    (sh_load),
        .sh_advance (sh_advance),
        .sh_sample  (sh_sample),
        .finish     (finish),
        .sclk       (spi_sclk),
        .ss_n       (spi_ss_n),
        .oe         (spi_mosi_oe),
        .done       (done)
    );

    // Publish the received word when the frame closes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (finish) begin
            rx_q <= rx_shift;
        end
    end

    assign rx_word = rx_q;

endmodule

// File: rtl/spi_clkdiv_master_sva.sv
// Protocol checker for spi_clkdiv_master, attached with bind.
// Assumes: observes ports only.
module spi_clkdiv_master_chk #(
    parameter int WORD_W = 8,
    parameter int DIV_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              spi_sclk,
    input logic              spi_ss_n,
    input logic              spi_mosi,
    input logic              spi_mosi_oe,
    input logic [WORD_W-1:0] rx_word,
    input logic              done
);

    // R8: clock rests high outside a frame
    a_r8_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        spi_ss_n |-> spi_sclk);

    // R8: clock moves only inside a frame
    a_r8_toggle_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk != $past(spi_sclk)) |-> (!spi_ss_n && !$past(spi_ss_n)));

    // R6: output enable only inside a frame
    a_r6_oe_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        spi_mosi_oe |-> !spi_ss_n);

    // R3: frame opens with data driven, clock resting, after a start
    a_r3_frame_open: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_ss_n) |-> (spi_mosi_oe && spi_sclk && $past(start)));

    // R4: driven data changes only on a rising serial edge
    a_r4_mosi_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_mosi_oe && $past(spi_mosi_oe) && (spi_mosi != $past(spi_mosi)))
            |-> $rose(spi_sclk));

    // R7: done is a single cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: done coincides with select release
    a_r7_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (spi_ss_n && !$past(spi_ss_n)));

    // R7: received word holds between done pulses
    a_r7_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rx_word));

endmodule

bind spi_clkdiv_master spi_clkdiv_master_chk #(
    .WORD_W(WORD_W),
    .DIV_W (DIV_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .spi_sclk    (spi_sclk),
    .spi_ss_n    (spi_ss_n),
    .spi_mosi    (spi_mosi),
    .spi_mosi_oe (spi_mosi_oe),
    .rx_word     (rx_word),
    .done        (done)
);

// File: tb/spi_clkdiv_master_bench.sv
`timescale 1ns/1ps
// Directed bench with a loopback slave model and an edge time-stamp monitor.
module spi_clkdiv_master_bench;

    localparam int W  = 8;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] clk_div = '0;
    logic          start = 1'b0;
    logic [W-1:0]  tx_word = '0;
    logic          spi_miso;
    logic          spi_sclk, spi_ss_n, spi_mosi, spi_mosi_oe, done;
    logic [W-1:0]  rx_word;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    spi_clkdiv_master #(.WORD_W(W), .DIV_W(DW)) u_spi_clkdiv_master (
        .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .start(start),
        .tx_word(tx_word), .spi_miso(spi_miso), .spi_sclk(spi_sclk),
        .spi_ss_n(spi_ss_n), .spi_mosi(spi_mosi), .spi_mosi_oe(spi_mosi_oe),
        .rx_word(rx_word), .done(done)
    );

    // Loopback slave: shifts out on rising, captures on falling
    logic [W-1:0] slv_word = '0;
    logic [W-1:0] slv_tx = '0;
    logic [W-1:0] slv_rx = '0;
    always @(negedge spi_ss_n) slv_tx = slv_word;
    always @(posedge spi_sclk) if (spi_ss_n === 1'b0) slv_tx = {slv_tx[W-2:0], 1'b0};
    always @(negedge spi_sclk) if (spi_ss_n === 1'b0) slv_rx = {slv_rx[W-2:0], spi_mosi};
    assign spi_miso = slv_tx[W-1];

    // Cycle counter and edge log
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int fall_t [64];
    int rise_t [64];
    int n_fall, n_rise, n_done, mosi_bad;
    int ss_fall_t, ss_rise_t, oe_fall_t, done_t;
    logic first_mosi, first_oe;
    logic p_sclk = 1'b1, p_ss = 1'b1, p_oe = 1'b0, p_mosi = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_ss && !spi_ss_n) begin
                ss_fall_t  = cyc;
                first_mosi = spi_mosi;
                first_oe   = spi_mosi_oe;
            end
            if (!p_ss && spi_ss_n) ss_rise_t = cyc;
            if (p_sclk && !spi_sclk) begin
                if (n_fall < 64) fall_t[n_fall] = cyc;
                n_fall++;
            end
            if (!p_sclk && spi_sclk) begin
                if (n_rise < 64) rise_t[n_rise] = cyc;
                n_rise++;
            end
            if (p_oe && !spi_mosi_oe) oe_fall_t = cyc;
            if (done) begin
                done_t = cyc;
                n_done++;
            end
            if (spi_mosi_oe && p_oe && (spi_mosi !== p_mosi) && !(!p_sclk && spi_sclk))
                mosi_bad++;
        end
        p_sclk = spi_sclk;
        p_ss   = spi_ss_n;
        p_oe   = spi_mosi_oe;
        p_mosi = spi_mosi;
    end

    task automatic clear_log();
        n_fall = 0; n_rise = 0; n_done = 0; mosi_bad = 0;
        ss_fall_t = -1; ss_rise_t = -1; oe_fall_t = -1; done_t = -1;
        first_mosi = 1'b0; first_oe = 1'b0;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R10: reset state
    task automatic test_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(spi_ss_n == 1'b1, "R10", "ss_n in reset", spi_ss_n, 1);
        chk(spi_sclk == 1'b1, "R10", "sclk in reset", spi_sclk, 1);
        chk(spi_mosi_oe == 1'b0, "R10", "oe in reset", spi_mosi_oe, 0);
        chk(done == 1'b0, "R10", "done in reset", done, 0);
        chk(rx_word == '0, "R10", "rx_word in reset", rx_word, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(spi_ss_n == 1'b1 && spi_sclk == 1'b1, "R10", "idle after reset",
            {spi_ss_n, spi_sclk}, 3);
    endtask

    // One transfer; optional mid-frame start and divider change (R9, R11)
    task automatic run_xfer(input int dv, input logic [W-1:0] tx,
                            input logic [W-1:0] sw, input bit poke);
        int de, per, lo, hi, t, bad_per, bad_lo, bad_hi;
        de  = (dv == 0) ? 1 : dv;
        per = de + 1;
        lo  = per / 2;
        hi  = (per + 1) / 2;
        @(negedge clk);
        clear_log();
        clk_div  = DW'(dv);
        tx_word  = tx;
        slv_word = sw;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            start   = 1'b1;
            tx_word = ~tx;
            clk_div = DW'(dv + 3);
            @(negedge clk);
            start   = 1'b0;
        end
        t = 0;
        while (n_done == 0 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        repeat (2 * per + 4) @(negedge clk);

        chk(first_mosi == tx[W-1] && first_oe, "R3", "first bit with select",
            first_mosi, tx[W-1]);
        chk(fall_t[0] - ss_fall_t == per, "R3", "select to first fall",
            fall_t[0] - ss_fall_t, per);
        bad_per = 0; bad_lo = 0; bad_hi = 0;
        for (int i = 0; i < W; i++) begin
            if (i > 0 && fall_t[i] - fall_t[i-1] != per) bad_per++;
            if (rise_t[i] - fall_t[i] != lo) bad_lo++;
            if (i < W - 1 && fall_t[i+1] - rise_t[i] != hi) bad_hi++;
        end
        chk(bad_per == 0, poke ? "R11" : "R1", "serial period errors", bad_per, 0);
        chk(bad_lo == 0, "R2", "low phase errors", bad_lo, 0);
        chk(bad_hi == 0, "R2", "high phase errors", bad_hi, 0);
        chk(rise_t[0] - fall_t[0] == lo, "R2", "first low phase",
            rise_t[0] - fall_t[0], lo);
        chk(n_fall == W && n_rise == W, "R8", "edge counts",
            n_fall * 100 + n_rise, W * 100 + W);
        chk(spi_sclk == 1'b1 && spi_ss_n == 1'b1, "R8", "rest state after frame",
            {spi_sclk, spi_ss_n}, 3);
        chk(slv_rx == tx, poke ? "R9" : "R4", "word seen by slave", slv_rx, tx);
        chk(mosi_bad == 0, "R4", "mosi changes off rising edge", mosi_bad, 0);
        chk(rx_word == sw, "R5", "received word", rx_word, sw);
        chk(oe_fall_t == rise_t[W-1], "R6", "oe drop at last rise",
            oe_fall_t, rise_t[W-1]);
        chk(ss_rise_t - rise_t[W-1] == hi, "R6", "last rise to release",
            ss_rise_t - rise_t[W-1], hi);
        chk(n_done == 1, poke ? "R9" : "R7", "done count", n_done, 1);
        chk(done_t == ss_rise_t, "R7", "done with release", done_t, ss_rise_t);
    endtask

    // R7: received word held until the next done
    task automatic test_rx_hold(input logic [W-1:0] exp);
        repeat (20) @(negedge clk);
        chk(rx_word == exp && !done, "R7", "rx_word held while idle", rx_word, exp);
    endtask

    initial begin
        #(200000 * 5);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        test_reset();
        run_xfer(1, 8'hA5, 8'h3C, 1'b0);   // period 2
        run_xfer(4, 8'h81, 8'hE7, 1'b0);   // even divider: 2 low, 3 high
        run_xfer(5, 8'h5A, 8'h0F, 1'b0);   // odd divider: 3 and 3
        run_xfer(0, 8'hFF, 8'h00, 1'b0);   // zero clamps to one
        run_xfer(8, 8'h01, 8'h80, 1'b0);   // even divider: 4 low, 5 high
        test_rx_hold(8'h80);
        run_xfer(2, 8'hC3, 8'h96, 1'b1);   // busy start ignored, divider change ignored
        run_xfer(7, 8'h00, 8'hFF, 1'b0);
        test_rx_hold(8'hFF);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule